// File: doc/BRIEF.md
# PHY Management Serial Master

This block runs clause-22 management transactions toward an Ethernet PHY over a two-wire serial link: a clock line (MDC) that it generates, and a shared bidirectional data line (MDIO). Software describes a whole transaction in one 32-bit frame word and writes it. The block then sends 32 preamble ones followed by the 32 bits of that word, most significant bit first.

For a read, the block releases the data line for the turnaround and data positions. It samples the 16 bits the PHY returns and puts them into the low half of the same frame word. At the end of every transaction it raises a completion bit in an event register. Software clears that bit by writing a one to it.

MDC is divided down from the system clock by a 6-bit field in a speed register. The same register holds a bit that delays each MDIO change by one system clock after the MDC falling edge, which gives the PHY extra hold time. A register port with a 2-bit select reaches the three registers: 0 is the frame word, 1 is the speed register, 2 is the event register, and 3 reads as zero.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy and mdc are 0, mdio_oe is 0, mdio_o is 1, and the frame, speed and event registers all read 0.
- R2: Writing the frame register (select 0) while idle with a nonzero divider sets busy on the next cycle. MDIO then carries 32 ones followed by frame bits 31 down to 0. Each bit is stable at the MDC rising edge that follows it.
- R3: The MDC period is 2 × (divider + 1) system clocks. A transaction keeps busy high for exactly 128 × (divider + 1) clocks. MDC is low whenever busy is low.
- R4: When frame bits 29:28 equal 10 (read), mdio_oe is low for the last 18 bit times (turnaround and data). The 16 bits sampled at the MDC rising edges of the last 16 bit times, first bit as the MSB, replace frame bits 15:0 at completion. Frame bits 31:16 are unchanged.
- R5: For any other value of frame bits 29:28, including 01 (write), the block drives all 64 bit times and leaves the frame register unchanged.
- R6: Completion sets bit 23 of the event register (select 2). Writing a 1 to bit 23 clears it, and writing 0 leaves it set. If completion and a clearing write fall in the same cycle, the bit stays set.
- R7: The speed register (select 1) stores the divider in bits 6:1 and the hold selector in bit 8. All other bits read as 0.
- R8: With a divider of 0, a frame write stores the word but starts nothing: busy stays low and no event is raised.
- R9: Frame and speed writes that arrive while busy is high are ignored.
- R10: With bit 8 of the speed register clear, MDIO changes in the same clock as the MDC falling edge. With bit 8 set, it changes one clock later.
- R11: While idle, mdio_oe is low, apart from the single clock after completion when the hold delay is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 frame, 1 speed, 2 event) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | Sampled level of the MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The assertions take for granted that reset is held for at least one clock before traffic starts. They also assume each register write is a one-cycle strobe with a stable select. The divider cannot change under a transaction, because speed writes are dropped while busy. The stimulus writes the speed register only while idle, and it keeps the start and turnaround fields at their conventional values so that the bit stream can be predicted from the frame word alone. The bench's PHY model drives mdio_i only after MDC falling edges in the read data phase and pulls it high at every other time, so every sampled level is defined.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W   = 32;
  localparam int PRE_BITS  = 32;
  localparam int DIV_BITS  = 6;
  localparam int EVT_POS   = 23;
  localparam int DIV_LSB   = 1;
  localparam int HOLD_POS  = 8;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef enum logic [1:0] {
    SEL_FRAME = 2'd0,
    SEL_SPEED = 2'd1,
    SEL_EVENT = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // value on the wire at a given bit time of the serial stream
  function automatic logic stream_bit(input logic [FRAME_W-1:0] fr,
                                      input int pre_len, input int pos);
    if (pos < pre_len) return 1'b1;
    return fr[5'(FRAME_W - 1 - (pos - pre_len))];
  endfunction

  // a read frame hands the line to the PHY from its turnaround on
  function automatic logic line_released(input logic rd, input int pre_len,
                                         input int pos);
    return rd && (pos >= pre_len + 14);
  endfunction

  function automatic int xfer_clocks(input int pre_len, input int div);
    return 2 * (pre_len + FRAME_W) * (div + 1);
  endfunction
endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick    = run && (cnt_q == div);
  assign rise_ev = tick && !mdc_q;
  assign fall_ev = tick && mdc_q;
  assign mdc     = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  half_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div));
  // R3
  mdc_toggle_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && !$past(tick) |-> $stable(mdc_q));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               rise_ev,
  input  logic               fall_ev,
  input  logic               mdio_i,
  output logic               busy,
  output logic               done,
  output logic               is_read,
  output logic               drv_o,
  output logic               drv_oe,
  output logic [15:0]        rx_data
);
  localparam int TOTAL  = PRE_LEN + FRAME_W;
  localparam int IDX_W  = $clog2(TOTAL);
  localparam int DATA_0 = TOTAL - 16;

  logic               busy_q;
  logic               rd_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] fr_q;
  logic [15:0]        rx_q;
  logic               in_data;

  assign in_data = (int'(idx_q) >= DATA_0);
  assign done    = busy_q && fall_ev && (idx_q == IDX_W'(TOTAL - 1));
  assign busy    = busy_q;
  assign is_read = rd_q;
  assign rx_data = rx_q;
  assign drv_o   = busy_q ? stream_bit(fr_q, PRE_LEN, int'(idx_q)) : 1'b1;
  assign drv_oe  = busy_q && !line_released(rd_q, PRE_LEN, int'(idx_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      fr_q   <= '0;
      rx_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      rd_q   <= (frame_in[29:28] == OP_RD);
      idx_q  <= '0;
      fr_q   <= frame_in;
      rx_q   <= '0;
    end else if (busy_q) begin
      if (rise_ev && rd_q && in_data) rx_q <= {rx_q[14:0], mdio_i};
      if (fall_ev) begin
        if (done) busy_q <= 1'b0;
        else      idx_q  <= idx_q + 1'b1;
      end
    end
  end

  // R9
  no_restart_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  // R2
  bit_advances_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !fall_ev |=> $stable(idx_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = DIV_BITS,
  parameter int PRE_LEN = PRE_BITS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [FRAME_W-1:0] frame_q;
  logic [DIV_W-1:0]   div_q;
  logic               hold_q;
  logic               evt_q;
  logic               pin_o_q, pin_oe_q;

  logic wr_frame, wr_speed, wr_event, start;
  logic rise_ev, fall_ev, done, is_read, drv_o, drv_oe;
  logic [15:0] rx_data;
  reg_sel_e sel;

  assign sel      = reg_sel_e'(reg_addr);
  assign wr_frame = reg_wr && (sel == SEL_FRAME);
  assign wr_speed = reg_wr && (sel == SEL_SPEED);
  assign wr_event = reg_wr && (sel == SEL_EVENT);
  assign start    = wr_frame && !busy && (div_q != '0);

  mdc_gen #(.DIV_W(DIV_W)) clk_div_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_seq #(.PRE_LEN(PRE_LEN)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_in(reg_wdata),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .mdio_i(mdio_i),
    .busy(busy), .done(done), .is_read(is_read),
    .drv_o(drv_o), .drv_oe(drv_oe), .rx_data(rx_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      div_q   <= '0;
      hold_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      if (wr_frame && !busy) frame_q <= reg_wdata;
      else if (done && is_read) frame_q[15:0] <= rx_data;
      if (wr_speed && !busy) begin
        div_q  <= reg_wdata[DIV_LSB +: DIV_W];
        hold_q <= reg_wdata[HOLD_POS];
      end
      evt_q <= (evt_q && !(wr_event && reg_wdata[EVT_POS])) || done;
    end
  end

  // one-clock hold stage behind the sequencer's pin values
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_o_q  <= 1'b1;
      pin_oe_q <= 1'b0;
    end else begin
      pin_o_q  <= drv_o;
      pin_oe_q <= drv_oe;
    end
  end

  assign mdio_o  = hold_q ? pin_o_q  : drv_o;
  assign mdio_oe = hold_q ? pin_oe_q : drv_oe;

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_FRAME: reg_rdata = frame_q;
      SEL_SPEED: begin
        reg_rdata[DIV_LSB +: DIV_W] = div_q;
        reg_rdata[HOLD_POS]         = hold_q;
      end
      SEL_EVENT: reg_rdata[EVT_POS] = evt_q;
      default:   reg_rdata = '0;
    endcase
  end

  // R6
  evt_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> evt_q);
  // R9
  frame_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(frame_q));
  // R9
  speed_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(div_q) && $stable(hold_q));
  // R8
  no_start_zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (div_q == '0) |=> !busy);
  // R3
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R11
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> !mdio_oe);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // PHY-side observation
  int          rise_cnt = 0;
  logic [63:0] got_bits = '0, got_oe = '0;
  time         t_r1 = 0, t_r2 = 0, t_wr = 0;
  logic        phy_rd = 1'b0;
  logic [15:0] phy_data = '0;

  always #(CLK_NS/2) clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always @(posedge mdc) begin
    rise_cnt = rise_cnt + 1;
    got_bits = {got_bits[62:0], mdio_o};
    got_oe   = {got_oe[62:0], mdio_oe};
    if (rise_cnt == 1) t_r1 = $time;
    if (rise_cnt == 2) t_r2 = $time;
  end

  always @(negedge mdc) begin
    if (phy_rd && rise_cnt >= 48 && rise_cnt < 64) mdio_i = phy_data[63 - rise_cnt];
    else mdio_i = 1'b1;
  end

  function automatic logic [63:0] exp_stream(input logic [31:0] f);
    return {32'hFFFF_FFFF, f};
  endfunction
  function automatic logic [63:0] exp_oe(input logic [31:0] f);
    return (f[29:28] == 2'b10) ? ~64'h3FFFF : '1;
  endfunction
  function automatic logic [31:0] exp_frame(input logic [31:0] f, input logic [15:0] d);
    return (f[29:28] == 2'b10) ? {f[31:16], d} : f;
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    t_wr = $time;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic xfer(input logic [31:0] f, input logic [15:0] d, input int div,
                      input bit hold, input bit intrude, input bit hold_chk,
                      input bit collide);
    logic [31:0] v;
    logic a, b;
    time t0, t_end;
    int n_exp;
    n_exp = 128 * (div + 1);
    wr(2'd1, (32'(div) << 1) | (32'(hold) << 8));
    phy_rd = (f[29:28] == 2'b10); phy_data = d;
    rise_cnt = 0; got_bits = '0; got_oe = '0;
    wr(2'd0, f);
    t0 = t_wr;
    chk(busy === 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    if (intrude) begin
      repeat (5) @(posedge clk);
      wr(2'd0, ~f);
      wr(2'd1, 32'h0000_0104);
    end
    if (hold_chk) begin
      repeat (32) @(negedge mdc);
      #1 a = mdio_o;
      @(posedge clk); #1 b = mdio_o;
      // R10: start bit 0 follows the preamble
      chk(a === (hold ? 1'b1 : 1'b0) && b === 1'b0, "R10 hold timing",
          {62'd0, a, b}, {62'd0, hold, 1'b0});
    end
    if (collide) begin
      repeat (n_exp - 1) @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0080_0000;
      @(posedge clk); #1 reg_wr = 1'b0;
    end
    while (busy) begin
      @(posedge clk); #1;
      if ($time - t0 > 64'(CLK_NS) * 20000) break;
    end
    t_end = $time;
    chk((t_end - t0) / CLK_NS == 64'(n_exp), "R3 busy length",
        64'((t_end - t0) / CLK_NS), 64'(n_exp));
    chk((t_r2 - t_r1) / CLK_NS == 64'(2 * (div + 1)), "R3 mdc period",
        64'((t_r2 - t_r1) / CLK_NS), 64'(2 * (div + 1)));
    chk(got_oe === exp_oe(f), phy_rd ? "R4 release pattern" : "R5 drive pattern",
        got_oe, exp_oe(f));
    chk((got_bits & got_oe) === (exp_stream(f) & exp_oe(f)), "R2 serial bits",
        got_bits & got_oe, exp_stream(f) & exp_oe(f));
    rd(2'd0, v);
    chk(v === exp_frame(f, d), phy_rd ? "R4 read data in frame" : "R5 frame kept",
        64'(v), 64'(exp_frame(f, d)));
    if (intrude) begin
      rd(2'd1, v);
      chk(v === ((32'(div) << 1) | (32'(hold) << 8)), "R9 speed kept", 64'(v),
          64'((32'(div) << 1) | (32'(hold) << 8)));
    end
    rd(2'd2, v);
    chk(v === 32'h0080_0000, collide ? "R6 set wins over clear" : "R6 event set",
        64'(v), 64'h0080_0000);
    wr(2'd2, 32'h0080_0000);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [31:0] v, f;
    logic [15:0] d;
    int div;
    void'($urandom(32'd4321));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(busy === 0 && mdc === 0 && mdio_oe === 0 && mdio_o === 1, "R1 pins",
        {60'd0, busy, mdc, mdio_oe, mdio_o}, 64'd1);
    for (int i = 0; i < 3; i++) begin
      rd(2'(i), v);
      chk(v === 32'd0, "R1 register zero", 64'(v), 64'd0);
    end
    // R8: divider 0 blocks the transaction
    wr(2'd0, 32'h5A5A_1234);
    repeat (4) @(posedge clk); #1;
    chk(busy === 1'b0, "R8 no start", 64'(busy), 64'd0);
    rd(2'd0, v);
    chk(v === 32'h5A5A_1234, "R8 word stored", 64'(v), 64'h5A5A_1234);
    rd(2'd2, v);
    chk(v === 32'd0, "R8 no event", 64'(v), 64'd0);
    // R7 field masking
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v);
    chk(v === 32'h0000_017E, "R7 speed fields", 64'(v), 64'h17E);
    // directed cases
    xfer(32'h5123_ABCD, 16'h0, 1, 1'b0, 1'b0, 1'b0, 1'b0);      // write, min div
    xfer(32'h6006_0000, 16'hBEEF, 2, 1'b0, 1'b0, 1'b1, 1'b0);   // read, hold off
    xfer(32'h6BFE_0000, 16'h8001, 2, 1'b1, 1'b0, 1'b1, 1'b0);   // read, hold on
    xfer(32'h7042_5555, 16'h0, 63, 1'b0, 1'b0, 1'b0, 1'b0);     // op 11, max div
    xfer(32'h5082_00F0, 16'h0, 3, 1'b0, 1'b1, 1'b0, 1'b0);      // R9 intrusion
    xfer(32'h6082_0000, 16'h1357, 3, 1'b1, 1'b1, 1'b0, 1'b0);   // R9 on a read
    xfer(32'h5000_0001, 16'h0, 2, 1'b0, 1'b0, 1'b0, 1'b1);      // R6 collision
    // R6 write-zero has no effect
    xfer(32'h4001_0000, 16'h0, 1, 1'b0, 1'b0, 1'b0, 1'b0);      // op 00
    wr(2'd1, 32'h2);
    wr(2'd0, 32'h5002_0000);
    while (busy) begin @(posedge clk); #1; end
    wr(2'd2, 32'hFF7F_FFFF);
    rd(2'd2, v);
    chk(v === 32'h0080_0000, "R6 zero write keeps bit", 64'(v), 64'h0080_0000);
    wr(2'd2, 32'h0080_0000);
    rd(2'd2, v);
    chk(v === 32'd0, "R6 cleared", 64'(v), 64'd0);
    // random traffic
    for (int k = 0; k < 10; k++) begin
      f = $urandom;
      f[31:30] = 2'b01; f[17:16] = 2'b10;
      f[29:28] = ($urandom % 4 == 0) ? 2'($urandom) : (($urandom % 2) ? 2'b10 : 2'b01);
      d = 16'($urandom);
      div = 1 + int'($urandom % 6);
      xfer(f, d, div, 1'($urandom), 1'b0, 1'b0, 1'b0);
    end
    @(negedge clk);
    chk(mdio_oe === 1'b0 && mdc === 1'b0, "R11 idle pins",
        {62'd0, mdio_oe, mdc}, 64'd0);
    report();
  end
endmodule